// File: doc/BRIEF.md
# Programmable Static Operand Router

This block is one tile of a mesh network that carries scalar operands between neighbouring processors. It has five ports: four mesh directions (north, east, south, west) and a local processor port. Which words go where is not decided by headers in the data. A program counter steps through a route schedule held in a small local instruction memory. That memory is filled through a write port before the schedule runs.

Each cycle the router looks at the instruction under its program counter. The instruction has a source select for every output, so one input word can be copied to several outputs at once. It may also carry a jump: an unconditional jump, or a jump on zero / non-zero that tests the word waiting on a named input. An instruction either completes as a whole or waits. It waits while any input it names is empty or any output it names is full, and while it waits nothing moves and the program counter holds. Every input is registered in a 4-deep FIFO with valid/ready flow control. Every output has a one-word buffer.

Top module: `sor_router`

## Requirements
- R1: After reset the program counter is 0, every input FIFO is empty (all `in_ready` bits high) and every `out_valid` bit is low.
- R2: The instruction word holds one 3-bit source select per output. Output p reads bits [3p+2:3p], with ports numbered N=0, E=1, S=2, W=3, P=4. The opcode sits at [17:15], the branch source at [20:18] and the jump target at [30:21]. Source codes are 0 for none and 1..5 for N, E, S, W, P; codes 6 and 7 mean none. When an instruction completes, each output with a valid select loads the head word of the named input.
- R3: One input may feed several outputs in the same instruction. Each of those outputs receives the word, and the input FIFO gives it up only once.
- R4: An instruction completes only when every input it names holds a word and every output it names can accept one. An output can accept when its buffer is empty or `out_ready` is high. Otherwise no word moves, no FIFO pops and the program counter holds.
- R5: Opcode 1 (jump on zero) tests the head word of its branch-source input and consumes it. It jumps to the target if the word is zero; otherwise it goes to the next address.
- R6: Opcode 2 (jump on non-zero) consumes its test word and jumps if the word is non-zero; otherwise it goes to the next address.
- R7: Opcode 3 jumps to the target unconditionally and consumes no test word. Opcode 0 and opcodes 4..7 always go to the next address. Addresses wrap at the memory depth.
- R8: Each input FIFO holds 4 words and delivers them in arrival order. `in_ready` is low exactly while the FIFO holds 4 words.
- R9: An output word stays on `out_data`, with `out_valid` high, until a cycle in which `out_ready` is high.
- R10: A word accepted on an input at one clock edge can appear on an output after the next edge at the earliest.
- R11: When the branch source is also a route source in the same instruction, the word is popped once and serves both uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Instruction memory write enable |
| imem_addr | input | IMEM_AW (6) | Instruction memory write address |
| imem_wdata | input | 32 | Instruction word to write |
| in_valid | input | 5 | Per-port input word valid (N,E,S,W,P = bits 0..4) |
| in_data | input | 5 x DW (160) | Per-port input words |
| in_ready | output | 5 | Per-port input FIFO can accept |
| out_valid | output | 5 | Per-port output buffer holds a word |
| out_data | output | 5 x DW (160) | Per-port output words |
| out_ready | input | 5 | Per-port downstream accepts the output word |

## Verification
The checks assume that reset is held for at least one edge, and that the instruction memory is written before the schedule is expected to mean anything. The bench loads the whole memory while reset is asserted and never writes it afterwards. They also assume the neighbours obey the handshake: a word counts only when `in_valid` and `in_ready` are both high. The bench drives `in_valid` freely, but its model counts only the handshaken words. Stimulus changes on the falling edge. The directed phases run the schedule through fan-out, both outcomes of each branch, a blocked destination and a full FIFO. A seeded random phase then toggles valid and ready on every port and makes about a third of the data words zero, so both branch outcomes keep occurring.

// File: rtl/sor_pkg.sv
package sor_pkg;
  localparam int NPORT = 5;
  localparam int SEL_W = 3;

  typedef enum logic [2:0] {
    OP_ROUTE = 3'd0,
    OP_JZ    = 3'd1,
    OP_JNZ   = 3'd2,
    OP_JMP   = 3'd3
  } op_e;

  typedef struct packed {
    logic                        spare;
    logic [9:0]                  target;
    logic [SEL_W-1:0]            bsrc;
    logic [2:0]                  op;
    logic [NPORT-1:0][SEL_W-1:0] sel;
  } rinstr_t;

  // one-hot input mask for a source code; codes outside 1..NPORT select nothing
  function automatic logic [NPORT-1:0] src_mask(logic [SEL_W-1:0] code);
    logic [NPORT-1:0] m;
    m = '0;
    for (int i = 0; i < NPORT; i++) if (code == SEL_W'(i + 1)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic tests_word(logic [2:0] op);
    return (op == OP_JZ) || (op == OP_JNZ);
  endfunction

  function automatic logic jump_taken(logic [2:0] op, logic word_is_zero);
    case (op)
      OP_JZ:   return word_is_zero;
      OP_JNZ:  return !word_is_zero;
      OP_JMP:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sor_in_fifo.sv
module sor_in_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          ready
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] slot [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        slot[wr_ptr] <= push_data;
        wr_ptr       <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head  = slot[rd_ptr];
  assign empty = (count == '0);
  assign ready = (count != CW'(DEPTH));
endmodule

// File: rtl/sor_out_buf.sv
module sor_out_buf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          drain,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end

  assign full = valid && !drain;
endmodule

// File: rtl/sor_sched.sv
module sor_sched
  import sor_pkg::*;
#(
  parameter int DW      = 32,
  parameter int IMEM_AW = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [IMEM_AW-1:0]         waddr,
  input  logic [31:0]                wdata,
  input  logic [NPORT-1:0][DW-1:0]   in_head,
  input  logic [NPORT-1:0]           in_empty,
  input  logic [NPORT-1:0]           out_full,
  output logic [NPORT-1:0]           pop_vec,
  output logic [NPORT-1:0]           load_vec,
  output logic [NPORT-1:0][DW-1:0]   route_data,
  output logic                       fire,
  output logic                       taken,
  output logic [IMEM_AW-1:0]         br_tgt,
  output logic [IMEM_AW-1:0]         pc
);
  localparam int DEPTH = 1 << IMEM_AW;

  logic [31:0]      imem [DEPTH];
  rinstr_t          ins;
  logic [NPORT-1:0] need_in, need_out;
  logic [DW-1:0]    test_word;
  logic             unused_bits;

  always_ff @(posedge clk) begin
    if (we) imem[waddr] <= wdata;
  end

  assign ins         = rinstr_t'(imem[pc]);
  assign unused_bits = ^{ins.spare, ins.target};

  always_comb begin
    need_in   = '0;
    need_out  = '0;
    test_word = '0;
    for (int o = 0; o < NPORT; o++) begin
      route_data[o] = '0;
      for (int i = 0; i < NPORT; i++)
        if (src_mask(ins.sel[o])[i]) route_data[o] = in_head[i];
      need_out[o] = |src_mask(ins.sel[o]);
      need_in     = need_in | src_mask(ins.sel[o]);
    end
    if (tests_word(ins.op)) begin
      need_in = need_in | src_mask(ins.bsrc);
      for (int i = 0; i < NPORT; i++)
        if (src_mask(ins.bsrc)[i]) test_word = in_head[i];
    end
  end

  assign fire     = !(|(need_in & in_empty)) && !(|(need_out & out_full));
  assign pop_vec  = fire ? need_in : '0;
  assign load_vec = fire ? need_out : '0;
  assign taken    = jump_taken(ins.op, test_word == '0);
  assign br_tgt   = ins.target[IMEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (fire) pc <= taken ? br_tgt : pc + 1'b1;
  end
endmodule

// File: rtl/sor_router.sv
module sor_router
  import sor_pkg::*;
#(
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int IMEM_AW    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     imem_we,
  input  logic [IMEM_AW-1:0]       imem_addr,
  input  logic [31:0]              imem_wdata,
  input  logic [NPORT-1:0]         in_valid,
  input  logic [NPORT-1:0][DW-1:0] in_data,
  output logic [NPORT-1:0]         in_ready,
  output logic [NPORT-1:0]         out_valid,
  output logic [NPORT-1:0][DW-1:0] out_data,
  input  logic [NPORT-1:0]         out_ready
);
  logic [NPORT-1:0]         in_empty, out_full, pop_vec, load_vec;
  logic [NPORT-1:0][DW-1:0] in_head, route_data;
  logic                     fire, taken;
  logic [IMEM_AW-1:0]       pc, br_tgt;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    sor_in_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .push(in_valid[p] && in_ready[p]), .push_data(in_data[p]),
      .pop(pop_vec[p]), .head(in_head[p]),
      .empty(in_empty[p]), .ready(in_ready[p])
    );
    sor_out_buf #(.DW(DW)) u_obuf (
      .clk(clk), .rst(rst),
      .load(load_vec[p]), .load_data(route_data[p]),
      .drain(out_ready[p]), .valid(out_valid[p]),
      .data(out_data[p]), .full(out_full[p])
    );
  end

  sor_sched #(.DW(DW), .IMEM_AW(IMEM_AW)) u_sched (
    .clk(clk), .rst(rst),
    .we(imem_we), .waddr(imem_addr), .wdata(imem_wdata),
    .in_head(in_head), .in_empty(in_empty), .out_full(out_full),
    .pop_vec(pop_vec), .load_vec(load_vec), .route_data(route_data),
    .fire(fire), .taken(taken), .br_tgt(br_tgt), .pc(pc)
  );
endmodule

// File: rtl/sor_router_chk.sv
module sor_router_chk
  import sor_pkg::*;
#(
  parameter int DW      = 32,
  parameter int IMEM_AW = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     fire,
  input logic                     taken,
  input logic [IMEM_AW-1:0]       br_tgt,
  input logic [IMEM_AW-1:0]       pc,
  input logic [NPORT-1:0]         pop_vec,
  input logic [NPORT-1:0]         load_vec,
  input logic [NPORT-1:0]         in_empty,
  input logic [NPORT-1:0]         out_full,
  input logic [NPORT-1:0]         in_ready,
  input logic [NPORT-1:0]         out_valid,
  input logic [NPORT-1:0]         out_ready,
  input logic [NPORT-1:0][DW-1:0] out_data
);
  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> (pc == '0) && (out_valid == '0) && (&in_ready));

  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !fire |=> pc == $past(pc));

  assert_jump_dest_R7: assert property (@(posedge clk) disable iff (rst)
    fire && taken |=> pc == $past(br_tgt));

  assert_pop_only_if_whole_R4: assert property (@(posedge clk) disable iff (rst)
    (|pop_vec) || (|load_vec) |-> fire);

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
      pop_vec[p] |-> !in_empty[p]);

    assert_load_room_R4: assert property (@(posedge clk) disable iff (rst)
      load_vec[p] |-> !out_full[p]);

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid[p] && !out_ready[p] |=> out_valid[p] && $stable(out_data[p]));

    assert_full_stays_R8: assert property (@(posedge clk) disable iff (rst)
      !in_ready[p] && !pop_vec[p] |=> !in_ready[p]);
  end
endmodule

bind sor_router sor_router_chk #(.DW(DW), .IMEM_AW(IMEM_AW)) u_chk (
  .clk(clk), .rst(rst), .fire(fire), .taken(taken), .br_tgt(br_tgt), .pc(pc),
  .pop_vec(pop_vec), .load_vec(load_vec), .in_empty(in_empty), .out_full(out_full),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sor_router_bench.sv
module sor_router_bench;
  localparam int NP = 5;
  localparam int AW = 6;
  localparam int MD = 64;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              imem_we = 1'b0;
  logic [AW-1:0]     imem_addr = '0;
  logic [31:0]       imem_wdata = '0;
  logic [NP-1:0]     in_valid = '0;
  logic [NP-1:0][31:0] in_data = '0;
  logic [NP-1:0]     in_ready;
  logic [NP-1:0]     out_valid;
  logic [NP-1:0][31:0] out_data;
  logic [NP-1:0]     out_ready = '1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [31:0] prog [MD];
  logic [31:0] mq [NP][$];
  bit          m_ov [NP];
  logic [31:0] m_od [NP];
  int          m_pc;

  sor_router u_sor_router (
    .clk(clk), .rst(rst), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_wdata(imem_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready)
  );

  always #5 clk = ~clk;

  // codes: 0 none, 1 N, 2 E, 3 S, 4 W, 5 P ; ops: 0 route, 1 jz, 2 jnz, 3 jmp
  function automatic logic [31:0] enc(int sn, int se, int ss, int sw, int sp,
                                      int op, int b, int tgt);
    return {1'b0, 10'(tgt), 3'(b), 3'(op), 3'(sp), 3'(sw), 3'(ss), 3'(se), 3'(sn)};
  endfunction

  task automatic model_step();
    logic [31:0] w;
    int code [NP];
    bit need_i [NP];
    bit need_o [NP];
    bit pushable [NP];
    bit ok;
    int op, b, tgt;
    logic [31:0] tv;
    bit jump;
    w   = prog[m_pc];
    op  = int'(w[17:15]);
    b   = int'(w[20:18]);
    tgt = int'(w[30:21]) % MD;
    for (int i = 0; i < NP; i++) begin
      need_i[i] = 0;
      pushable[i] = in_valid[i] && (mq[i].size() < 4);
    end
    for (int o = 0; o < NP; o++) begin
      code[o] = int'((w >> (3 * o)) & 32'h7);
      need_o[o] = (code[o] >= 1 && code[o] <= 5);
      if (need_o[o]) need_i[code[o] - 1] = 1;
    end
    if ((op == 1 || op == 2) && b >= 1 && b <= 5) need_i[b - 1] = 1;
    ok = 1;
    for (int i = 0; i < NP; i++) if (need_i[i] && mq[i].size() == 0) ok = 0;
    for (int o = 0; o < NP; o++) if (need_o[o] && m_ov[o] && !out_ready[o]) ok = 0;
    for (int o = 0; o < NP; o++) begin
      if (ok && need_o[o]) begin
        m_ov[o] = 1;
        m_od[o] = mq[code[o] - 1][0];
      end else if (out_ready[o]) begin
        m_ov[o] = 0;
      end
    end
    if (ok) begin
      tv = (b >= 1 && b <= 5) ? mq[b - 1][0] : 32'h0;
      jump = (op == 3) || (op == 1 && tv == 0) || (op == 2 && tv != 0);
      m_pc = jump ? tgt : (m_pc + 1) % MD;
      for (int i = 0; i < NP; i++) if (need_i[i]) void'(mq[i].pop_front());
    end
    for (int i = 0; i < NP; i++) if (pushable[i]) mq[i].push_back(in_data[i]);
  endtask

  task automatic compare(string tag);
    logic [NP-1:0] er, ev;
    for (int i = 0; i < NP; i++) begin
      er[i] = (mq[i].size() < 4);
      ev[i] = m_ov[i];
    end
    checks++;
    if (in_ready !== er) begin
      errors++;
      $display("FAIL %s in_ready actual %b expected %b at %0t", tag, in_ready, er, $time);
    end
    checks++;
    if (out_valid !== ev) begin
      errors++;
      $display("FAIL %s out_valid actual %b expected %b at %0t", tag, out_valid, ev, $time);
    end
    for (int i = 0; i < NP; i++) begin
      if (ev[i]) begin
        checks++;
        if (out_data[i] !== m_od[i]) begin
          errors++;
          $display("FAIL %s out_data[%0d] actual %h expected %h at %0t",
                   tag, i, out_data[i], m_od[i], $time);
        end
      end
    end
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic send(int port, logic [31:0] val, string tag);
    in_valid = '0;
    in_valid[port] = 1'b1;
    in_data[port] = val;
    tick(tag);
    in_valid = '0;
  endtask

  task automatic idle(int n, string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  initial begin
    for (int a = 0; a < MD; a++) prog[a] = 32'h0;
    prog[0] = enc(0, 5, 5, 0, 0, 0, 0, 0);  // E<-P, S<-P
    prog[1] = enc(0, 0, 0, 0, 4, 1, 4, 4);  // P<-W, jump on zero W to 4
    prog[2] = enc(0, 1, 0, 0, 0, 2, 1, 0);  // E<-N, jump on non-zero N to 0
    prog[3] = enc(0, 0, 0, 2, 0, 3, 0, 0);  // W<-E, jump to 0
    prog[4] = enc(3, 0, 0, 0, 0, 0, 0, 0);  // N<-S
    prog[5] = enc(0, 0, 0, 0, 0, 3, 0, 0);  // jump to 0
    for (int i = 0; i < NP; i++) m_ov[i] = 0;
    m_pc = 0;

    @(negedge clk);
    for (int a = 0; a < MD; a++) begin
      imem_we = 1'b1;
      imem_addr = AW'(a);
      imem_wdata = prog[a];
      @(negedge clk);
    end
    imem_we = 1'b0;
    rst = 1'b0;
    compare("R1");

    // R3/R10: processor word fans out to east and south
    send(4, 32'h11, "R10");
    idle(2, "R3");
    // R11/R5: zero test word on west, also routed to processor
    send(3, 32'h0, "R11");
    idle(1, "R5");
    // R2: pc now 4, south word routed north
    send(2, 32'h22, "R2");
    idle(2, "R7");
    send(4, 32'h33, "R7");
    idle(1, "R7");
    // R5: non-zero west word falls through
    send(3, 32'h5, "R5");
    // R6: non-zero north word jumps back
    send(0, 32'h7, "R6");
    idle(2, "R6");
    // R4/R9: east blocked, processor word waits
    out_ready = 5'b11101;
    send(4, 32'h44, "R4");
    idle(3, "R9");
    out_ready = '1;
    idle(2, "R4");
    // R8: fill north FIFO while the schedule waits on west
    out_ready = '0;
    for (int k = 0; k < 6; k++) send(0, 32'h100 + k, "R8");
    out_ready = '1;
    send(3, 32'h3, "R8");
    idle(6, "R8");

    // random phase
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < NP; i++) begin
        in_valid[i] = ($urandom_range(0, 9) < 6);
        in_data[i]  = ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom;
        out_ready[i] = ($urandom_range(0, 9) < 7);
      end
      tick("R2");
    end
    in_valid = '0;
    out_ready = '1;
    idle(20, "R4");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule